// File: doc/BRIEF.md
# Processor-to-DRAM Cycle Sequencer

This block connects a pipelined processor bus to a page-mode DRAM. The processor announces each bus cycle with two strobes, a memory-request strobe (active low) and a sequential flag, together with an address, a write flag and write data. The sequencer accepts an announcement on every rising clock edge where its wait output is low. It then plays out the matching DRAM phases: precharge, row strobe with the row half of the address, and column strobe with the column half. It also drives the read data back toward the processor with a drive enable.

Internal cycles and coprocessor register transfers are bus cycles with no memory access. Neither of them may start a DRAM access. Both release the row, so the following access begins from a precharged bank. This matters most when an internal cycle is followed by a non-sequential jump: the row must come from the jump address, never from whatever appeared on the bus during the internal cycle. A sequential access after an internal cycle is treated as a merged cycle. The precharge has already taken place inside the internal cycle, so the row strobe is raised in the first clock of the sequential access.

Control pins are plain level signals. The only back-pressure is the wait output. While it is high the processor holds its announcement, and the sequencer does not sample the strobes, address or data.

Top module: `cpu_dram_cycle_ctrl`

## Requirements
- R1: The pair {memory-request, sequential} decodes as 00 non-sequential, 01 sequential, 10 internal, 11 coprocessor transfer.
- R2: After an internal cycle is accepted, row and column strobes stay high and no drive enable is raised in the following clock.
- R3: A non-sequential cycle after an internal cycle raises the row strobe with the row field of its own address, not the address seen during the internal cycle.
- R4: A coprocessor transfer starts no DRAM access: strobes stay high and a write flag presented with it changes no DRAM word.
- R5: During a coprocessor transfer the read-data drive enable stays low.
- R6: A sequential cycle that follows an internal or coprocessor cycle costs exactly one wait clock (row, then column) with no precharge clock.
- R7: A non-sequential cycle costs two wait clocks (precharge, row) when a row was open and one wait clock when the bank was closed, then a column clock with wait low.
- R8: A sequential cycle in the open row issues only a column strobe and costs zero wait clocks.
- R9: A sequential cycle whose row field differs from the open row costs two wait clocks, like a non-sequential cycle.
- R10: The row field is address bits [11:6] and goes out on the DRAM address while only the row strobe is low; the column field, bits [5:0], goes out while the column strobe is low.
- R11: The read-data drive enable is high only in the column clock of a read; in a write column clock the DRAM write strobe is low and the read enable stays low.
- R12: Reset, even in the middle of an access, forces both strobes high, wait low, all enables low, and leaves the bank closed.
- R13: Announcement inputs that change while wait is high have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mreq_n | input | 1 | Memory-request strobe, active low |
| seq | input | 1 | Sequential flag |
| cpu_addr | input | ADDR_W | Byte address of the announced cycle |
| cpu_write | input | 1 | Announced cycle is a write |
| cpu_wdata | input | DATA_W | Write data from the processor |
| cpu_rdata | output | DATA_W | Read data toward the processor, zero when not driving |
| cpu_rdata_oe | output | 1 | Drive enable for read data onto the processor bus |
| cpu_wait | output | 1 | Holds the processor during precharge and row clocks |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | DRAM write strobe, active low |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for write data toward the DRAM |
| dram_dq_in | input | DATA_W | Read data from the DRAM |

## Verification
The hardest situation to reach is an internal cycle that carries an unrelated address, followed at once by a non-sequential jump. A second hard case is a coprocessor transfer announced with the write flag set while a row is still open. Either one exposes a sequencer that commits early. The stimulus table orders its entries so that both are preceded by open rows in distant pages. The read-back that follows each one shows whether the wrong row was opened or a word was overwritten. A directed step then changes the address during a wait clock. Another raises reset in the middle of a row opening.

// File: rtl/cpu_dram_pkg.sv
package cpu_dram_pkg;

  // Bus cycle kinds, encoded as {mreq_n, seq}
  typedef enum logic [1:0] {
    CYC_N = 2'b00,
    CYC_S = 2'b01,
    CYC_I = 2'b10,
    CYC_C = 2'b11
  } cyc_kind_e;

  // DRAM sequencing phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ROW  = 2'd2,
    PH_COL  = 2'd3
  } dram_phase_e;

endpackage

// File: rtl/bus_cycle_decode.sv
module bus_cycle_decode
  import cpu_dram_pkg::*;
(
  input  logic      mreq_n,
  input  logic      seq,
  output cyc_kind_e kind,
  output logic      is_mem
);

  always_comb begin
    unique case ({mreq_n, seq})
      2'b00:   kind = CYC_N;
      2'b01:   kind = CYC_S;
      2'b10:   kind = CYC_I;
      default: kind = CYC_C;
    endcase
  end

  assign is_mem = (kind == CYC_N) || (kind == CYC_S);

endmodule

// File: rtl/dram_phase_fsm.sv
module dram_phase_fsm
  import cpu_dram_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cyc_kind_e   kind,
  input  logic        is_mem,
  input  logic        row_hit,
  output dram_phase_e phase,
  output logic        accept,
  output logic        take
);

  dram_phase_e phase_nxt;
  logic        row_live;

  // A new announcement is sampled only in a clock that ends a bus cycle
  assign accept   = (phase == PH_IDLE) || (phase == PH_COL);
  assign row_live = (phase == PH_COL);
  assign take     = accept && is_mem;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_PRE: phase_nxt = PH_ROW;
      PH_ROW: phase_nxt = PH_COL;
      default: begin
        unique case (kind)
          CYC_N:   phase_nxt = row_live ? PH_PRE : PH_ROW;
          CYC_S: begin
            if (!row_live)    phase_nxt = PH_ROW;
            else if (row_hit) phase_nxt = PH_COL;
            else              phase_nxt = PH_PRE;
          end
          default: phase_nxt = PH_IDLE;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path
  import cpu_dram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 6,
  parameter int DATA_W = 8,
  parameter int MUX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  dram_phase_e       phase,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_write,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] dram_dq_in,
  output logic              row_hit,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe
);

  localparam int ROW_W = ADDR_W - COL_W;

  logic [ADDR_W-1:0] acc_addr;
  logic              acc_write;
  logic [DATA_W-1:0] acc_wdata;
  logic [ROW_W-1:0]  acc_row;
  logic [COL_W-1:0]  acc_col;
  logic              in_col;

  // Only memory cycles commit an address; internal and coprocessor
  // announcements never reach these registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr  <= '0;
      acc_write <= 1'b0;
      acc_wdata <= '0;
    end else if (take) begin
      acc_addr  <= cpu_addr;
      acc_write <= cpu_write;
      acc_wdata <= cpu_wdata;
    end
  end

  assign acc_row = acc_addr[ADDR_W-1:COL_W];
  assign acc_col = acc_addr[COL_W-1:0];
  assign row_hit = (cpu_addr[ADDR_W-1:COL_W] == acc_row);
  assign in_col  = (phase == PH_COL);

  generate
    if (ROW_W >= COL_W) begin : g_row_wide
      always_comb begin
        unique case (phase)
          PH_ROW:  dram_addr = acc_row;
          PH_COL:  dram_addr = MUX_W'(acc_col);
          default: dram_addr = '0;
        endcase
      end
    end else begin : g_col_wide
      always_comb begin
        unique case (phase)
          PH_ROW:  dram_addr = MUX_W'(acc_row);
          PH_COL:  dram_addr = acc_col;
          default: dram_addr = '0;
        endcase
      end
    end
  endgenerate

  assign dram_we_n    = !(in_col && acc_write);
  assign dram_dq_oe   = in_col && acc_write;
  assign dram_dq_out  = dram_dq_oe ? acc_wdata : '0;
  assign cpu_rdata_oe = in_col && !acc_write;
  assign cpu_rdata    = cpu_rdata_oe ? dram_dq_in : '0;

endmodule

// File: rtl/cpu_dram_cycle_ctrl.sv
module cpu_dram_cycle_ctrl
  import cpu_dram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 6,
  parameter int DATA_W = 8,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic              seq,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_write,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic              cpu_wait,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [MUX_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  cyc_kind_e   kind;
  logic        is_mem;
  logic        row_hit;
  logic        accept;
  logic        take;
  dram_phase_e phase;

  bus_cycle_decode u_decode (
    .mreq_n (mreq_n),
    .seq    (seq),
    .kind   (kind),
    .is_mem (is_mem)
  );

  dram_phase_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .is_mem  (is_mem),
    .row_hit (row_hit),
    .phase   (phase),
    .accept  (accept),
    .take    (take)
  );

  dram_addr_path #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .MUX_W  (MUX_W)
  ) u_path (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .phase        (phase),
    .cpu_addr     (cpu_addr),
    .cpu_write    (cpu_write),
    .cpu_wdata    (cpu_wdata),
    .dram_dq_in   (dram_dq_in),
    .row_hit      (row_hit),
    .dram_addr    (dram_addr),
    .dram_we_n    (dram_we_n),
    .dram_dq_out  (dram_dq_out),
    .dram_dq_oe   (dram_dq_oe),
    .cpu_rdata    (cpu_rdata),
    .cpu_rdata_oe (cpu_rdata_oe)
  );

  assign cpu_wait   = !accept;
  assign dram_ras_n = !((phase == PH_ROW) || (phase == PH_COL));
  assign dram_cas_n = !(phase == PH_COL);

endmodule

// File: rtl/cpu_dram_cycle_chk.sv
module cpu_dram_cycle_chk (
  input logic clk,
  input logic rst_n,
  input logic mreq_n,
  input logic seq,
  input logic cpu_wait,
  input logic cpu_rdata_oe,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n
);

  // R2 R4
  no_commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wait && mreq_n) |=> (dram_ras_n && dram_cas_n));

  // R5
  coproc_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wait && mreq_n && seq) |=> !cpu_rdata_oe);

  // R11
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> (!cpu_rdata_oe && !dram_cas_n));

  // R10
  col_inside_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  // R7
  row_open_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> cpu_wait);

  // R7
  row_then_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && !dram_ras_n) |=> (!dram_cas_n && !cpu_wait));

endmodule

bind cpu_dram_cycle_ctrl cpu_dram_cycle_chk u_cycle_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mreq_n       (mreq_n),
  .seq          (seq),
  .cpu_wait     (cpu_wait),
  .cpu_rdata_oe (cpu_rdata_oe),
  .dram_ras_n   (dram_ras_n),
  .dram_cas_n   (dram_cas_n),
  .dram_we_n    (dram_we_n)
);

// File: tb/cpu_dram_cycle_ctrl_test.sv
module cpu_dram_cycle_ctrl_test;

  localparam int AW = 12;
  localparam int CW = 6;
  localparam int DW = 8;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mreq_n = 1'b1;
  logic          seq = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_write = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_rdata_oe;
  logic          cpu_wait;
  logic          dram_ras_n;
  logic          dram_cas_n;
  logic          dram_we_n;
  logic [CW-1:0] dram_addr;
  logic [DW-1:0] dram_dq_out;
  logic          dram_dq_oe;
  logic [DW-1:0] dram_dq_in;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  cpu_dram_cycle_ctrl uut (
    .clk (clk), .rst_n (rst_n), .mreq_n (mreq_n), .seq (seq),
    .cpu_addr (cpu_addr), .cpu_write (cpu_write), .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata), .cpu_rdata_oe (cpu_rdata_oe), .cpu_wait (cpu_wait),
    .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
    .dram_addr (dram_addr), .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe),
    .dram_dq_in (dram_dq_in)
  );

  // Behavioural page-mode DRAM
  logic [DW-1:0] dram_mem [1 << AW];
  logic [AW-CW-1:0] open_row = '0;
  logic             row_valid = 1'b0;

  initial for (int i = 0; i < (1 << AW); i++) dram_mem[i] = '0;

  always @(posedge clk) begin
    if (dram_ras_n) row_valid <= 1'b0;
    else if (!row_valid) begin
      open_row  <= dram_addr;
      row_valid <= 1'b1;
    end
    if (!dram_cas_n && !dram_we_n && dram_dq_oe && row_valid)
      dram_mem[{open_row, dram_addr}] <= dram_dq_out;
  end

  assign dram_dq_in = (!dram_cas_n && row_valid) ? dram_mem[{open_row, dram_addr}] : '0;

  // Expected memory contents, kept by the bench from the requirements
  logic [DW-1:0] shadow [1 << AW];
  initial for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // {expected waits[1:0], kind {mreq_n,seq}[1:0], write, addr[11:0], data[7:0]}
  localparam logic [24:0] VECS [NV] = '{
    {2'd1, 2'b00, 1'b1, 12'h0C5, 8'h11},
    {2'd0, 2'b01, 1'b1, 12'h0C6, 8'h22},
    {2'd0, 2'b01, 1'b0, 12'h0C5, 8'h00},
    {2'd0, 2'b10, 1'b0, 12'h7FF, 8'h00},
    {2'd1, 2'b00, 1'b0, 12'h0C6, 8'h00},
    {2'd0, 2'b11, 1'b0, 12'h000, 8'h00},
    {2'd1, 2'b01, 1'b0, 12'h0C5, 8'h00},
    {2'd2, 2'b01, 1'b1, 12'h100, 8'h33},
    {2'd2, 2'b00, 1'b1, 12'h9A7, 8'h44},
    {2'd2, 2'b00, 1'b0, 12'h100, 8'h00},
    {2'd0, 2'b10, 1'b0, 12'h9A7, 8'h00},
    {2'd1, 2'b01, 1'b0, 12'h9A7, 8'h00},
    {2'd2, 2'b00, 1'b0, 12'h9A8, 8'h00},
    {2'd0, 2'b10, 1'b0, 12'h3C0, 8'h00},
    {2'd1, 2'b00, 1'b1, 12'h040, 8'h55},
    {2'd0, 2'b01, 1'b0, 12'h040, 8'h00},
    {2'd0, 2'b11, 1'b1, 12'h0C5, 8'h66},
    {2'd1, 2'b01, 1'b0, 12'h0C5, 8'h00}
  };

  // Drive one announcement at a negedge, return at the negedge of its last clock
  task automatic run_cycle(input logic [24:0] v);
    logic [1:0]    exp_w;
    logic [1:0]    kind;
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            waits;
    {exp_w, kind, we, a, d} = v;
    mreq_n    = kind[1];
    seq       = kind[0];
    cpu_write = we;
    cpu_addr  = a;
    cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    waits = 0;
    while (cpu_wait && waits < 6) begin
      if (!dram_ras_n)
        check(dram_addr == a[AW-1:CW], "R3 R10 row address", dram_addr, a[AW-1:CW]);
      waits++;
      @(negedge clk);
    end
    check(waits == exp_w, "R1 R6 R7 R8 R9 wait clocks", waits, exp_w);
    if (!kind[1]) begin
      check(!dram_cas_n && !dram_ras_n, "R10 column strobe", dram_cas_n, 0);
      check(dram_addr == a[CW-1:0], "R10 column address", dram_addr, a[CW-1:0]);
      if (we) begin
        check(!dram_we_n && !cpu_rdata_oe, "R11 write strobes", {dram_we_n, cpu_rdata_oe}, 0);
        shadow[a] = d;
      end else begin
        check(cpu_rdata_oe, "R11 read enable", cpu_rdata_oe, 1);
        check(cpu_rdata == shadow[a], "R4 R11 read data", cpu_rdata, shadow[a]);
      end
    end else begin
      check(dram_ras_n && dram_cas_n, "R2 R4 strobes idle", {dram_ras_n, dram_cas_n}, 3);
      check(!cpu_rdata_oe && !dram_dq_oe, "R2 R5 no drive", {cpu_rdata_oe, dram_dq_oe}, 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int waits;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(dram_ras_n && dram_cas_n && !cpu_wait, "R12 reset strobes", {dram_ras_n, dram_cas_n, cpu_wait}, 6);
    check(!cpu_rdata_oe && !dram_dq_oe && dram_we_n, "R12 reset enables", {cpu_rdata_oe, dram_dq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_cycle(VECS[i]);

    // R13: announcement changed during a wait clock is ignored
    mreq_n = 1'b0; seq = 1'b0; cpu_write = 1'b0; cpu_addr = 12'h100;
    @(posedge clk);
    @(negedge clk);
    check(cpu_wait, "R13 wait raised", cpu_wait, 1);
    mreq_n = 1'b1; cpu_addr = 12'hFFF; cpu_write = 1'b1;
    waits = 0;
    while (cpu_wait && waits < 6) begin waits++; @(negedge clk); end
    check(dram_addr == 6'h00 && !dram_cas_n, "R13 held column", dram_addr, 0);
    check(cpu_rdata_oe && cpu_rdata == shadow[12'h100], "R13 held read", cpu_rdata, shadow[12'h100]);

    // R12: reset in the middle of a row opening
    mreq_n = 1'b0; seq = 1'b0; cpu_write = 1'b0; cpu_addr = 12'h0C5;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n && !cpu_wait, "R12 reset mid access", {dram_ras_n, dram_cas_n, cpu_wait}, 6);
    rst_n = 1'b1;
    run_cycle({2'd1, 2'b01, 1'b0, 12'h0C5, 8'h00});

    finish_run();
  end

endmodule